// File: doc/BRIEF.md
# Clock-Manager Reset Sequencer

This block produces the reset for a delay-locked loop or clock manager. It holds the reset high from power-on and waits for the device's startup phases to complete. It then issues a reset pulse of fixed width, counted on the loop's own input clock, and releases the reset so the loop can acquire lock. The startup phase that qualifies the pulse depends on a static strap. With external feedback, both the write-enable release and the output-enable (tristate) release must have happened. With internal feedback, the write-enable release alone is enough.

After the first pulse, the sequencer keeps watching the loop. A loss of lock after lock was reached issues a fresh pulse. So does a lock that never arrives within a wait window. A free-running reference clock measures gaps in the input clock. A gap longer than a set time (about 100 µs in the default setting) re-arms the reset once input-clock edges return. Startup and lock inputs pass through two-flop synchronizers into the input-clock domain.

The states are WAIT_STARTUP (code 0), RESET (1), WAIT_LOCK (2) and LOCKED (3). The transitions are:
- start: WAIT_STARTUP → RESET, when the startup phases qualify.
- pulse_done: RESET → WAIT_LOCK, after the pulse width has elapsed.
- acquired: WAIT_LOCK → LOCKED, when lock is seen.
- lock_timeout: WAIT_LOCK → RESET, when the wait window expires without lock.
- lock_lost: LOCKED → RESET, when lock falls.
- stall_rearm: RESET, WAIT_LOCK or LOCKED → RESET, after a long input-clock stall. In RESET it restarts the pulse.

Top module: `clkmgr_rst_seq`

## Requirements
- R1: After `rst_n` is released, the state is WAIT_STARTUP (code 0) and `mgr_rst` is high. The block stays there until the startup phases qualify.
- R2: With `ext_fb`=1, the start transition needs both `wen_done` and `tris_done` high. `wen_done` alone leaves the state in WAIT_STARTUP.
- R3: With `ext_fb`=0, `wen_done` high alone is enough for the start transition.
- R4: The RESET state (code 1) lasts exactly PULSE_W input-clock cycles with `mgr_rst` high. The block then enters WAIT_LOCK (code 2) with `mgr_rst` low.
- R5: In WAIT_LOCK, a synchronized high on `lock_in` moves the state to LOCKED (code 3). A low lock has no effect in RESET, and no effect in WAIT_LOCK before the window ends.
- R6: If lock is not seen within LOCK_WAIT input-clock cycles in WAIT_LOCK, the block returns to RESET and issues a new pulse.
- R7: In LOCKED, a fall of the synchronized `lock_in` sends the block to RESET.
- R8: If `clk_in` stops for longer than STALL_REF reference-clock cycles, the block enters RESET once `clk_in` edges return.
- R9: A `clk_in` gap shorter than the stall threshold has no effect on the state.
- R10: `state_o` carries the state code. `mgr_rst` is high exactly in codes 0 and 1, and the block never returns to code 0 except through `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Loop input clock; clocks the sequencer |
| ref_clk | input | 1 | Free-running reference clock for stall timing |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_fb | input | 1 | Static strap: 1 = loop uses external feedback |
| wen_done | input | 1 | Startup write-enable release has happened |
| tris_done | input | 1 | Startup tristate release has happened |
| lock_in | input | 1 | Lock indication from the clock manager |
| mgr_rst | output | 1 | Active-high reset to the clock manager |
| state_o | output | 2 | State code: 0 WAIT_STARTUP, 1 RESET, 2 WAIT_LOCK, 3 LOCKED |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. The state machine stays in WAIT_STARTUP while its startup qualifier is missing. The pulse counter holds RESET until the width has elapsed. A lock drop in LOCKED forces RESET, WAIT_STARTUP is never re-entered, and the stall counter stays within its limit. Other behaviours depend on how the clock and lock are driven over time, and only the bench's scenarios can show them. These are the exact pulse width, the lock-wait timeout, the re-arm after a real input-clock stall, the absence of any reaction to a short gap, and the choice of startup qualifier under each strap value.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_RST    = 2'd1,
        ST_WLOCK  = 2'd2,
        ST_LOCKED = 2'd3
    } seq_state_e;
endpackage

// File: rtl/crs_sync2.sv
module crs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/crs_stall_mon.sv
module crs_stall_mon #(
    parameter int STALL_REF = 10000
) (
    input  logic clk_in,
    input  logic ref_clk,
    input  logic rst_n,
    output logic stall_flag
);
    localparam int SW = $clog2(STALL_REF + 1);
    localparam logic [SW-1:0] LIM = SW'(STALL_REF);

    logic          div2_q;
    logic          tog_s;
    logic          tog_prev_q;
    logic [SW-1:0] gap_cnt_q;
    logic          flag_q;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) div2_q <= 1'b0;
        else        div2_q <= ~div2_q;
    end

    crs_sync2 #(.W(1)) u_tog_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .din  (div2_q),
        .dout (tog_s)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_prev_q <= 1'b0;
            gap_cnt_q  <= '0;
            flag_q     <= 1'b0;
        end else begin
            tog_prev_q <= tog_s;
            if (tog_s != tog_prev_q) begin
                gap_cnt_q <= '0;
                flag_q    <= 1'b0;
            end else if (gap_cnt_q == LIM) begin
                flag_q    <= 1'b1;
            end else begin
                gap_cnt_q <= gap_cnt_q + 1'b1;
            end
        end
    end

    assign stall_flag = flag_q;

    // R8
    gap_cnt_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        gap_cnt_q <= LIM);

    // R9
    flag_needs_full_gap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(gap_cnt_q) == LIM);
endmodule

// File: rtl/crs_seq_fsm.sv
module crs_seq_fsm
    import clkrst_pkg::*;
#(
    parameter int PULSE_W   = 8,
    parameter int LOCK_WAIT = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_fb,
    input  logic       wen_s,
    input  logic       tris_s,
    input  logic       lock_s,
    input  logic       stall_s,
    output seq_state_e state_q,
    output logic       mgr_rst_q
);
    localparam int MAXC = (PULSE_W > LOCK_WAIT) ? PULSE_W : LOCK_WAIT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PW_LAST = CW'(PULSE_W - 1);
    localparam logic [CW-1:0] LW_LAST = CW'(LOCK_WAIT - 1);

    seq_state_e    state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          stall_prev_q;
    logic          stall_rise;
    logic          start_ok;

    assign stall_rise = stall_s & ~stall_prev_q;
    assign start_ok   = wen_s & (~ext_fb | tris_s);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WAIT: begin
                cnt_d = '0;
                if (start_ok) state_d = ST_RST;
            end
            ST_RST: begin
                if (stall_rise) begin
                    cnt_d = '0;
                end else if (cnt_q == PW_LAST) begin
                    state_d = ST_WLOCK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WLOCK: begin
                if (stall_rise) begin
                    state_d = ST_RST;
                    cnt_d   = '0;
                end else if (lock_s) begin
                    state_d = ST_LOCKED;
                    cnt_d   = '0;
                end else if (cnt_q == LW_LAST) begin
                    state_d = ST_RST;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOCKED: begin
                cnt_d = '0;
                if (stall_rise || !lock_s) state_d = ST_RST;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_WAIT;
            cnt_q        <= '0;
            stall_prev_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            stall_prev_q <= stall_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mgr_rst_q <= 1'b1;
        else        mgr_rst_q <= (state_d == ST_WAIT) || (state_d == ST_RST);
    end

    // R2
    hold_without_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !wen_s) |=> state_q == ST_WAIT);

    // R2
    hold_without_tris_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ext_fb && !tris_s) |=> state_q == ST_WAIT);

    // R4
    pulse_not_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST && cnt_q < PW_LAST) |=> state_q == ST_RST);

    // R7
    lock_drop_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !lock_s) |=> state_q == ST_RST);

    // R10
    no_return_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |=> state_q != ST_WAIT);

    // R10
    rst_out_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgr_rst_q == (state_q == ST_WAIT || state_q == ST_RST));
endmodule

// File: rtl/clkmgr_rst_seq.sv
module clkmgr_rst_seq
    import clkrst_pkg::*;
#(
    parameter int PULSE_W   = 8,
    parameter int LOCK_WAIT = 1024,
    parameter int STALL_REF = 10000
) (
    input  logic       clk_in,
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       ext_fb,
    input  logic       wen_done,
    input  logic       tris_done,
    input  logic       lock_in,
    output logic       mgr_rst,
    output logic [1:0] state_o
);
    logic       stall_ref;
    logic [3:0] ci_s;
    seq_state_e st;

    crs_stall_mon #(.STALL_REF(STALL_REF)) u_stall (
        .clk_in    (clk_in),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .stall_flag(stall_ref)
    );

    crs_sync2 #(.W(4)) u_ci_sync (
        .clk  (clk_in),
        .rst_n(rst_n),
        .din  ({stall_ref, lock_in, tris_done, wen_done}),
        .dout (ci_s)
    );

    crs_seq_fsm #(.PULSE_W(PULSE_W), .LOCK_WAIT(LOCK_WAIT)) u_fsm (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .ext_fb   (ext_fb),
        .wen_s    (ci_s[0]),
        .tris_s   (ci_s[1]),
        .lock_s   (ci_s[2]),
        .stall_s  (ci_s[3]),
        .state_q  (st),
        .mgr_rst_q(mgr_rst)
    );

    assign state_o = st;
endmodule

// File: tb/sim_clkmgr_rst_seq.sv
module sim_clkmgr_rst_seq;
    localparam int PW = 8;
    localparam int LW = 64;
    localparam int SR = 50;

    logic clk_raw = 1'b0;
    logic clk_en  = 1'b1;
    logic ref_clk = 1'b0;
    logic clk_in;
    logic rst_n = 1'b0;
    logic ext_fb = 1'b1, wen_done = 1'b0, tris_done = 1'b0, lock_in = 1'b0;
    logic mgr_rst;
    logic [1:0] state_o;

    int n_chk = 0, n_bad = 0;
    int    exp_st_q[$];
    string exp_req_q[$];
    logic [1:0] prev_st = 2'd0;
    int run_len = 0;
    bit done = 0;

    always #5 clk_raw = ~clk_raw;
    always #6.5 ref_clk = ~ref_clk;
    assign clk_in = clk_raw & clk_en;

    clkmgr_rst_seq #(.PULSE_W(PW), .LOCK_WAIT(LW), .STALL_REF(SR)) u0 (
        .clk_in(clk_in), .ref_clk(ref_clk), .rst_n(rst_n), .ext_fb(ext_fb),
        .wen_done(wen_done), .tris_done(tris_done), .lock_in(lock_in),
        .mgr_rst(mgr_rst), .state_o(state_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(string req, int st);
        exp_st_q.push_back(st);
        exp_req_q.push_back(req);
    endtask

    task automatic drain();
        wait (exp_st_q.size() == 0);
        repeat (2) @(negedge clk_raw);
    endtask

    // monitor: compare each observed state change with the next queued item
    always @(negedge clk_in) begin
        if (!rst_n) begin
            prev_st = state_o;
            run_len = 0;
        end else begin
            if (state_o == 2'd1) run_len++;
            if (state_o != prev_st) begin
                if (prev_st == 2'd1) chk("R4 pulse width", run_len, PW);
                if (state_o != 2'd1) run_len = 0;
                if (exp_st_q.size() == 0) begin
                    chk("R9 unexpected transition", state_o, prev_st);
                end else begin
                    automatic int    e = exp_st_q.pop_front();
                    automatic string r = exp_req_q.pop_front();
                    chk(r, state_o, e);
                    chk({r, " R10 reset level"}, mgr_rst, (e < 2) ? 1 : 0);
                end
                prev_st = state_o;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk_raw);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_raw);
        rst_n = 1'b1;
        repeat (6) @(negedge clk_raw);
        chk("R1 state after reset", state_o, 0);
        chk("R1 reset output", mgr_rst, 1);

        // external feedback: write-enable alone is not enough
        wen_done = 1'b1;
        repeat (20) @(negedge clk_raw);
        chk("R2 wen only", state_o, 0);
        chk("R2 reset held", mgr_rst, 1);

        // tristate release completes qualifier; no lock -> timeout re-pulse
        push("R2 start", 1); push("R4 release", 2);
        push("R6 timeout", 1); push("R4 release again", 2);
        tris_done = 1'b1;
        drain();
        chk("R5 low lock keeps waiting", state_o, 2);
        push("R5 acquired", 3);
        lock_in = 1'b1;
        drain();
        chk("R5 locked out", mgr_rst, 0);

        // lock loss
        push("R7 lock lost", 1); push("R7 release", 2);
        lock_in = 1'b0;
        drain();
        push("R5 reacquired", 3);
        lock_in = 1'b1;
        drain();

        // short clock gap: no effect
        @(negedge clk_raw); clk_en = 1'b0;
        #260;
        @(negedge clk_raw); clk_en = 1'b1;
        repeat (30) @(negedge clk_raw);
        chk("R9 short gap state", state_o, 3);

        // long stall: re-arm after edges return
        push("R8 stall rearm", 1); push("R8 release", 2); push("R8 relock", 3);
        @(negedge clk_raw); clk_en = 1'b0;
        #1300;
        @(negedge clk_raw); clk_en = 1'b1;
        drain();

        // internal feedback: write-enable alone starts the pulse
        rst_n = 1'b0;
        lock_in = 1'b0; wen_done = 1'b0; tris_done = 1'b0; ext_fb = 1'b0;
        repeat (4) @(negedge clk_raw);
        rst_n = 1'b1;
        repeat (10) @(negedge clk_raw);
        chk("R1 wait again", state_o, 0);
        push("R3 start", 1); push("R3 release", 2);
        wen_done = 1'b1;
        drain();
        push("R3 acquired", 3);
        lock_in = 1'b1;
        drain();
        chk("R10 locked code", state_o, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule